// File: doc/BRIEF.md
# Transmit Packet Queue Manager

This block sits between a host that composes outgoing frames and a MAC transmitter that takes bytes. The host writes 16-bit words into an on-chip packet store. Each frame is laid out as a control word, then a payload byte count, then the payload packed two bytes per word. When every word of a frame has been written, the host pulses `commit`. The block checks that the header agrees with the number of words written, and then adds the frame to the send queue. If they do not agree, it discards the words.

A reader takes queued frames in commit order. It parses the two header words and streams the payload as bytes over a valid/ready interface with start and end markers. A trailing pad byte is dropped when the count is odd. The reader also carries a per-frame flag that tells the MAC whether to append a CRC.

A free-space counter in words is visible to the host. A frame's storage is returned only after the MAC has accepted its last byte. Writes that find no free space are refused, so queued data is never overwritten. The status outputs describe the frame currently on the wire. That frame can be older than the most recently committed one.

Top module: `tx_pkt_queue`

## Requirements
- R1: After reset, `free_words` is 3072 (6 KB of 16-bit words), `queued_frames` is 0, and `out_valid`, `tx_busy` and `commit_rej` are 0.
- R2: In a frame, word 0 is the control word and word 1 is the payload byte count. Payload byte k is in word 2+k/2: bits 7:0 for even k and bits 15:8 for odd k. Bytes leave in increasing k.
- R3: A commit is accepted only when three conditions hold. The words written since the previous commit, including a word written in the commit cycle, must number exactly 2+ceil(count/2). The count must be at least 1. The count must be at most 2000. Otherwise those words are discarded, their space is returned, and `commit_rej` is 1 for the one cycle after the commit.
- R4: While `wr_ready` is 0 (no free word), a write is refused. It changes neither the free count nor any stored frame.
- R5: Each accepted write lowers `free_words` by one. A frame's 2+ceil(count/2) words are returned in the cycle after its last byte is accepted.
- R6: Only committed frames are sent, in commit order. `queued_frames` counts committed frames not yet started.
- R7: `out_sof` marks the first byte and `out_eof` marks byte number count. While `out_valid` is 1 and `out_ready` is 0, data and markers hold.
- R8: With `cfg_big_endian` at 1, the two bytes of the control word and of the byte count are exchanged before use. Payload bytes are never exchanged.
- R9: `out_append_crc` equals `cfg_crc_gen` as sampled when the frame starts, and stays constant for that frame. Both configuration inputs are held while frames are queued.
- R10: `tx_busy` is 1 from the cycle after a frame starts until its last byte is accepted. While it is 1, `tx_ctrl` shows that frame's control word.
- R11: With the reader idle and `queued_frames` nonzero, the control word is taken at the next edge and the count at the following edge. The first byte is then valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_big_endian | input | 1 | Exchange header bytes before use |
| cfg_crc_gen | input | 1 | MAC must append CRC to frames started while set |
| wr_en | input | 1 | Host writes one word |
| wr_data | input | 16 | Host word |
| wr_ready | output | 1 | A free word exists; writes are taken |
| commit | input | 1 | Close the frame being written |
| commit_rej | output | 1 | Previous commit was refused |
| free_words | output | 12 | Free words in the store |
| queued_frames | output | 12 | Committed frames not yet started |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | MAC accepts byte |
| out_data | output | 8 | Payload byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_append_crc | output | 1 | MAC appends CRC to this frame |
| tx_busy | output | 1 | A frame is being sent |
| tx_ctrl | output | 16 | Control word of the frame being sent |

## Verification
The hardest state to reach is an exactly full store. In that state the oldest frame is stalled on the wire while further writes are refused, and the status must still describe the stalled frame rather than the newest one. The bench holds `out_ready` low and queues three maximum-length frames. It then writes a fourth frame sized to take the last free word, and adds writes past that point. Finally it releases the stream with a random ready pattern, so that space comes back frame by frame in the middle of later traffic.

// File: rtl/tpq_pkg.sv
package tpq_pkg;
   localparam int WORD_W = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {RD_IDLE, RD_COUNT, RD_DATA} rd_state_e;

   function automatic logic [WORD_W-1:0] hdr_order(input logic [WORD_W-1:0] w,
                                                    input logic big_end);
      return big_end ? {w[BYTE_W-1:0], w[WORD_W-1:BYTE_W]} : w;
   endfunction
endpackage

// File: rtl/tpq_store.sv
module tpq_store #(
   parameter int DEPTH = 3072,
   parameter int AW    = 12
) (
   input  logic                       clk,
   input  logic                       we,
   input  logic [AW-1:0]              waddr,
   input  logic [tpq_pkg::WORD_W-1:0] wdata,
   input  logic [AW-1:0]              raddr,
   output logic [tpq_pkg::WORD_W-1:0] rdata
);
   logic [tpq_pkg::WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/tpq_writer.sv
module tpq_writer
   import tpq_pkg::*;
#(
   parameter int DEPTH     = 3072,
   parameter int AW        = 12,
   parameter int CW        = 12,
   parameter int MAX_BYTES = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_big_endian,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              can_write,
   input  logic              commit,
   output logic              wr_acc,
   output logic [AW-1:0]     mem_waddr,
   output logic              frame_ok,
   output logic [CW-1:0]     give_back,
   output logic              rej_q
);
   logic [AW-1:0]     wr_ptr, start_ptr, wr_ptr_after;
   logic [CW-1:0]     fr_words, words_now;
   logic [WORD_W-1:0] fr_bc, bc_now;
   logic [16:0]       need;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
      return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
   endfunction

   assign wr_acc       = wr_en & can_write;
   assign mem_waddr    = wr_ptr;
   assign wr_ptr_after = wr_acc ? step(wr_ptr) : wr_ptr;
   assign words_now    = fr_words + CW'(wr_acc);
   assign bc_now       = (wr_acc && fr_words == CW'(1)) ? hdr_order(wr_data, cfg_big_endian)
                                                        : fr_bc;
   assign need         = 17'd2 + ((17'(bc_now) + 17'd1) >> 1);
   assign frame_ok     = commit && (words_now >= CW'(2)) && (bc_now != '0) &&
                         (32'(bc_now) <= 32'(MAX_BYTES)) && (17'(words_now) == need);
   assign give_back    = (commit && !frame_ok) ? words_now : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         start_ptr <= '0;
         fr_words  <= '0;
         fr_bc     <= '0;
         rej_q     <= 1'b0;
      end else begin
         rej_q <= commit && !frame_ok;
         if (wr_acc && fr_words == CW'(1)) fr_bc <= hdr_order(wr_data, cfg_big_endian);
         if (commit) begin
            fr_words <= '0;
            if (frame_ok) begin
               wr_ptr    <= wr_ptr_after;
               start_ptr <= wr_ptr_after;
            end else begin
               wr_ptr <= start_ptr;
            end
         end else if (wr_acc) begin
            wr_ptr   <= wr_ptr_after;
            fr_words <= fr_words + CW'(1);
         end
      end
   end
endmodule

// File: rtl/tpq_reader.sv
module tpq_reader
   import tpq_pkg::*;
#(
   parameter int DEPTH          = 3072,
   parameter int AW             = 12,
   parameter int CW             = 12,
   parameter bit LOW_BYTE_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_big_endian,
   input  logic              cfg_crc_gen,
   input  logic              have_frame,
   output logic              take_frame,
   output logic [AW-1:0]     raddr,
   input  logic [WORD_W-1:0] rdata,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_sof,
   output logic              out_eof,
   output logic              out_append_crc,
   output logic              tx_busy,
   output logic [WORD_W-1:0] tx_ctrl,
   output logic [CW-1:0]     release_words
);
   rd_state_e         st;
   logic [AW-1:0]     rd_ptr;
   logic [WORD_W-1:0] remain, bc_q, ctrl_q, bc_in;
   logic              lane, first, crc_q, last_take;
   logic [16:0]       frame_len;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
      return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
   endfunction

   generate
      if (LOW_BYTE_FIRST) begin : g_low_first
         assign out_data = lane ? rdata[WORD_W-1:BYTE_W] : rdata[BYTE_W-1:0];
      end else begin : g_high_first
         assign out_data = lane ? rdata[BYTE_W-1:0] : rdata[WORD_W-1:BYTE_W];
      end
   endgenerate

   assign bc_in          = hdr_order(rdata, cfg_big_endian);
   assign raddr          = rd_ptr;
   assign take_frame     = (st == RD_IDLE) && have_frame;
   assign out_valid      = (st == RD_DATA);
   assign out_sof        = out_valid && first;
   assign out_eof        = out_valid && (remain == WORD_W'(1));
   assign out_append_crc = crc_q;
   assign tx_busy        = (st != RD_IDLE);
   assign tx_ctrl        = ctrl_q;
   assign last_take      = out_eof && out_ready;
   assign frame_len      = 17'd2 + ((17'(bc_q) + 17'd1) >> 1);
   assign release_words  = last_take ? CW'(frame_len) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= RD_IDLE;
         rd_ptr <= '0;
         remain <= '0;
         bc_q   <= '0;
         ctrl_q <= '0;
         lane   <= 1'b0;
         first  <= 1'b0;
         crc_q  <= 1'b0;
      end else begin
         unique case (st)
            RD_IDLE: if (have_frame) begin
               ctrl_q <= hdr_order(rdata, cfg_big_endian);
               crc_q  <= cfg_crc_gen;
               rd_ptr <= step(rd_ptr);
               st     <= RD_COUNT;
            end
            RD_COUNT: begin
               bc_q   <= bc_in;
               remain <= bc_in;
               rd_ptr <= step(rd_ptr);
               lane   <= 1'b0;
               first  <= 1'b1;
               st     <= RD_DATA;
            end
            RD_DATA: if (out_ready) begin
               remain <= remain - WORD_W'(1);
               first  <= 1'b0;
               if (lane || remain == WORD_W'(1)) begin
                  rd_ptr <= step(rd_ptr);
                  lane   <= 1'b0;
               end else begin
                  lane <= 1'b1;
               end
               if (remain == WORD_W'(1)) st <= RD_IDLE;
            end
            default: st <= RD_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tx_pkt_queue.sv
module tx_pkt_queue
   import tpq_pkg::*;
#(
   parameter int  MEM_BYTES      = 6144,
   parameter int  MAX_BYTES      = 2000,
   parameter bit  LOW_BYTE_FIRST = 1'b1,
   localparam int DEPTH          = MEM_BYTES / 2,
   localparam int AW             = $clog2(DEPTH),
   localparam int CW             = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_big_endian,
   input  logic          cfg_crc_gen,
   input  logic          wr_en,
   input  logic [15:0]   wr_data,
   output logic          wr_ready,
   input  logic          commit,
   output logic          commit_rej,
   output logic [CW-1:0] free_words,
   output logic [CW-1:0] queued_frames,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [7:0]    out_data,
   output logic          out_sof,
   output logic          out_eof,
   output logic          out_append_crc,
   output logic          tx_busy,
   output logic [15:0]   tx_ctrl
);
   generate
      if (MEM_BYTES % 2 != 0) begin : g_bad_size
         $error("tx_pkt_queue: MEM_BYTES must be even");
      end
      if (MAX_BYTES < 1 || MAX_BYTES > 65535) begin : g_bad_max
         $error("tx_pkt_queue: MAX_BYTES out of range");
      end
      if (2 + (MAX_BYTES + 1) / 2 > DEPTH) begin : g_too_small
         $error("tx_pkt_queue: store cannot hold one maximum frame");
      end
   endgenerate

   logic              wr_acc, frame_ok, take_frame;
   logic [AW-1:0]     waddr, raddr;
   logic [WORD_W-1:0] rdata;
   logic [CW-1:0]     give_back, release_words, free_q, queued_q;

   tpq_writer #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .MAX_BYTES(MAX_BYTES)) u_writer (
      .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian),
      .wr_en(wr_en), .wr_data(wr_data), .can_write(wr_ready), .commit(commit),
      .wr_acc(wr_acc), .mem_waddr(waddr), .frame_ok(frame_ok),
      .give_back(give_back), .rej_q(commit_rej)
   );

   tpq_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
      .clk(clk), .we(wr_acc), .waddr(waddr), .wdata(wr_data),
      .raddr(raddr), .rdata(rdata)
   );

   tpq_reader #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .LOW_BYTE_FIRST(LOW_BYTE_FIRST)) u_reader (
      .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian), .cfg_crc_gen(cfg_crc_gen),
      .have_frame(queued_q != '0), .take_frame(take_frame), .raddr(raddr), .rdata(rdata),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sof(out_sof), .out_eof(out_eof), .out_append_crc(out_append_crc),
      .tx_busy(tx_busy), .tx_ctrl(tx_ctrl), .release_words(release_words)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_q   <= CW'(DEPTH);
         queued_q <= '0;
      end else begin
         free_q   <= free_q - CW'(wr_acc) + give_back + release_words;
         queued_q <= queued_q + CW'(frame_ok) - CW'(take_frame);
      end
   end

   assign wr_ready      = (free_q != '0);
   assign free_words    = free_q;
   assign queued_frames = queued_q;
endmodule

// File: rtl/tpq_checks.sv
module tpq_checks #(
   parameter int DEPTH = 3072,
   parameter int CW    = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic          wr_ready,
   input logic          commit,
   input logic [CW-1:0] free_words,
   input logic [CW-1:0] queued_frames,
   input logic          out_valid,
   input logic          out_ready,
   input logic [7:0]    out_data,
   input logic          out_sof,
   input logic          out_eof,
   input logic          out_append_crc,
   input logic          tx_busy,
   input logic [15:0]   tx_ctrl
);
   a_r5_free_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      free_words <= CW'(DEPTH));

   a_r5_write_costs_one: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ready && !commit && !(out_valid && out_ready && out_eof))
      |=> free_words == $past(free_words) - CW'(1));

   a_r4_refused_write_free: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ready && !commit && !(out_valid && out_ready && out_eof))
      |=> free_words == $past(free_words));

   a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready)
      |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof));

   a_r7_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> tx_busy);

   a_r6_start_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> $past(queued_frames) != '0);

   a_r9_crc_flag_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && $past(tx_busy)) |-> $stable(out_append_crc));

   a_r10_ctrl_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && $past(tx_busy)) |-> $stable(tx_ctrl));
endmodule

bind tx_pkt_queue tpq_checks #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ready(wr_ready), .commit(commit),
   .free_words(free_words), .queued_frames(queued_frames), .out_valid(out_valid),
   .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
   .out_append_crc(out_append_crc), .tx_busy(tx_busy), .tx_ctrl(tx_ctrl)
);

// File: tb/tb_tx_pkt_queue.sv
module tb_tx_pkt_queue;
   localparam int DEPTH = 3072;
   localparam int MAXB  = 2000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cfg_be = 1'b0, cfg_crc = 1'b0;
   logic        wr_en = 1'b0, commit = 1'b0, out_ready = 1'b0;
   logic [15:0] wr_data = '0;
   logic        wr_ready, commit_rej, out_valid, out_sof, out_eof, out_append_crc, tx_busy;
   logic [11:0] free_words, queued_frames;
   logic [7:0]  out_data;
   logic [15:0] tx_ctrl;

   tx_pkt_queue dut (
      .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_be), .cfg_crc_gen(cfg_crc),
      .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready), .commit(commit),
      .commit_rej(commit_rej), .free_words(free_words), .queued_frames(queued_frames),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sof(out_sof), .out_eof(out_eof), .out_append_crc(out_append_crc),
      .tx_busy(tx_busy), .tx_ctrl(tx_ctrl)
   );

   always #5 clk = ~clk;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int          m_free = DEPTH, m_st = 0, m_rem = 0, m_bc = 0;
   logic [15:0] m_ctrl = '0;
   bit          m_crc = 0, m_first = 0, m_rej = 0;
   logic [15:0] pend[$];
   logic [15:0] q_ctrl[$];
   int          q_bc[$];
   logic [7:0]  pay[$];

   function automatic logic [15:0] hs(input logic [15:0] w);
      return cfg_be ? {w[7:0], w[15:8]} : w;
   endfunction

   always @(posedge clk) begin : model
      int acc, rel, gb, n, bcv;
      bit ok;
      if (!rst_n) begin
         m_free = DEPTH; m_st = 0; m_rem = 0; m_bc = 0; m_ctrl = '0;
         m_crc = 0; m_first = 0; m_rej = 0;
         pend.delete(); q_ctrl.delete(); q_bc.delete(); pay.delete();
      end else begin
         acc = (wr_en && m_free > 0) ? 1 : 0;
         rel = 0; gb = 0;
         case (m_st)
            0: if (q_ctrl.size() > 0) begin
                  m_ctrl = q_ctrl.pop_front(); m_crc = cfg_crc; m_st = 1;
               end
            1: begin m_bc = q_bc.pop_front(); m_rem = m_bc; m_first = 1; m_st = 2; end
            default: if (out_ready) begin
                  void'(pay.pop_front());
                  m_rem--; m_first = 0;
                  if (m_rem == 0) begin rel = 2 + (m_bc + 1) / 2; m_st = 0; end
               end
         endcase
         if (acc != 0) pend.push_back(wr_data);
         m_rej = 0;
         if (commit) begin
            n = pend.size(); ok = 0; bcv = 0;
            if (n >= 2) begin
               bcv = int'(hs(pend[1]));
               ok = (bcv >= 1 && bcv <= MAXB && n == 2 + (bcv + 1) / 2);
            end
            if (ok) begin
               q_ctrl.push_back(hs(pend[0]));
               q_bc.push_back(bcv);
               for (int k = 0; k < bcv; k++)
                  pay.push_back((k % 2 == 0) ? pend[2 + k / 2][7:0] : pend[2 + k / 2][15:8]);
            end else begin
               gb = n; m_rej = 1;
            end
            pend.delete();
         end
         m_free = m_free - acc + gb + rel;
      end
   end

   // ---------------- compare every cycle ----------------
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5 free_words", 32'(free_words), 32'(m_free));
         chk("R6 queued_frames", 32'(queued_frames), 32'(q_ctrl.size()));
         chk("R4 wr_ready", 32'(wr_ready), 32'(m_free > 0));
         chk("R3 commit_rej", 32'(commit_rej), 32'(m_rej));
         chk("R10 tx_busy", 32'(tx_busy), 32'(m_st != 0));
         chk("R11 out_valid", 32'(out_valid), 32'(m_st == 2));
         if (m_st != 0) chk("R10 tx_ctrl", 32'(tx_ctrl), 32'(m_ctrl));
         if (m_st == 2) begin
            // R8: header exchange affects where the stream starts and ends
            chk(cfg_be ? "R8 out_data" : "R2 out_data", 32'(out_data), 32'(pay[0]));
            chk("R7 out_sof", 32'(out_sof), 32'(m_first));
            chk("R7 out_eof", 32'(out_eof), 32'(m_rem == 1));
            chk("R9 out_append_crc", 32'(out_append_crc), 32'(m_crc));
         end
      end
   end

   // ---------------- ready patterns ----------------
   int ready_mode = 2;
   logic [15:0] lfsr = 16'hACE1;
   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (ready_mode)
         0: out_ready <= 1'b1;
         1: out_ready <= lfsr[0] | lfsr[3];
         default: out_ready <= 1'b0;
      endcase
   end

   // ---------------- stimulus ----------------
   task automatic wr(input logic [15:0] w);
      wr_en = 1'b1; wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_commit();
      commit = 1'b1;
      @(negedge clk);
      commit = 1'b0;
   endtask

   function automatic logic [7:0] pb(input logic [7:0] seed, input int idx, input int bc);
      return (idx >= bc) ? 8'hEE : 8'(seed + 8'(idx * 7));
   endfunction

   // nwords < 0: exact payload word count; merge: last word shares the commit cycle
   task automatic send(input logic [15:0] ctrl, input int bc, input int nwords,
                       input bit merge, input logic [7:0] seed);
      int pw;
      logic [15:0] w;
      pw = (nwords < 0) ? (bc + 1) / 2 : nwords;
      wr(hs(ctrl));
      wr(hs(16'(bc)));
      for (int i = 0; i < pw; i++) begin
         w = {pb(seed, 2 * i + 1, bc), pb(seed, 2 * i, bc)};
         if (merge && i == pw - 1) begin
            wr_en = 1'b1; wr_data = w; commit = 1'b1;
            @(negedge clk);
            wr_en = 1'b0; commit = 1'b0;
         end else begin
            wr(w);
         end
      end
      if (!merge || pw == 0) pulse_commit();
   endtask

   task automatic wait_idle();
      while (q_ctrl.size() != 0 || m_st != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 free after reset", 32'(free_words), 32'(DEPTH));
      chk("R1 queued after reset", 32'(queued_frames), 0);
      chk("R1 out_valid after reset", 32'(out_valid), 0);
      chk("R1 tx_busy after reset", 32'(tx_busy), 0);
      chk("R1 commit_rej after reset", 32'(commit_rej), 0);

      // R2 R7 R11: basic frames, odd and even lengths, full-rate ready
      ready_mode = 0; cfg_crc = 1'b1;
      send(16'h1001, 1, -1, 0, 8'h10);
      send(16'h1002, 2, -1, 0, 8'h20);
      send(16'h1003, 3, -1, 0, 8'h30);
      send(16'h1004, 10, -1, 0, 8'h40);
      send(16'h1005, 61, -1, 0, 8'h50);
      wait_idle();

      // R7: stalls from a random ready pattern, commit sharing the last write (R3)
      ready_mode = 1;
      send(16'h2001, 7, -1, 1, 8'h60);
      send(16'h2002, 64, -1, 1, 8'h70);
      send(16'h2003, 5, -1, 0, 8'h80);
      wait_idle();

      // R3: rejected commits
      send(16'h3001, MAXB + 1, (MAXB + 2) / 2, 0, 8'h90);
      send(16'h3002, 0, 0, 0, 8'hA0);
      send(16'h3003, 10, 4, 0, 8'hB0);
      pulse_commit();
      send(16'h3004, 9, -1, 0, 8'hC0);
      wait_idle();

      // R8 R9: big-endian headers, no CRC append
      cfg_be = 1'b1; cfg_crc = 1'b0;
      send(16'h4A5B, 9, -1, 0, 8'hD0);
      send(16'h0102, 300, -1, 0, 8'hE0);
      wait_idle();
      cfg_be = 1'b0; cfg_crc = 1'b1;

      // R10: status follows the stalled frame, not the newest one
      ready_mode = 2;
      send(16'h5001, 4, -1, 0, 8'h01);
      send(16'h5002, 6, -1, 0, 8'h02);
      send(16'h5003, 8, -1, 0, 8'h03);
      repeat (5) @(negedge clk);
      chk("R10 ctrl of oldest frame", 32'(tx_ctrl), 32'h5001);
      ready_mode = 0;
      wait_idle();

      // R4 R5: overflow attempt, refused words, then rejected commit
      ready_mode = 2;
      send(16'h6001, MAXB, DEPTH + 20, 0, 8'h11);
      ready_mode = 0;
      wait_idle();

      // R4 R5: store filled exactly, refused writes while full
      ready_mode = 2;
      send(16'h7001, MAXB, -1, 0, 8'h21);
      send(16'h7002, MAXB, -1, 0, 8'h22);
      send(16'h7003, MAXB, -1, 0, 8'h23);
      send(16'h7004, 2 * (DEPTH - 3 * (2 + MAXB / 2) - 2), -1, 0, 8'h24);
      chk("R4 store full", 32'(free_words), 0);
      wr(16'hDEAD);
      wr(16'hBEEF);
      chk("R4 refused writes leave free at 0", 32'(free_words), 0);
      pulse_commit();
      ready_mode = 1;
      wait_idle();
      chk("R5 all space returned", 32'(free_words), 32'(DEPTH));

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule